// File: doc/BRIEF.md
# AC97 Codec Register Access Controller

This block carries single register reads and writes from a host to an AC97 codec. The host starts one access at a time with a request: a direction bit, an 8-bit register address and, for writes, a 16-bit value. The controller holds the request until the next outgoing frame begins. In that frame it fills the command address slot and the command data slot and raises their slot-valid tags.

A write is finished once its frame has been loaded. A read then waits for an incoming frame whose status slots are tagged valid and whose status address names the requested register. From that frame it captures the returned 16-bit value. If no such frame arrives within a set number of outgoing frames, the read is abandoned.

Two update flags report whether the captured status address and the captured status data differ from the values already held. Reading an unchanged register twice therefore leaves both flags low. Frame timing, PCM slots and codec reset pins belong to neighbouring logic.

Top module: `ac97_regacc_ctrl`

## Requirements
- R1: For a write, the command address slot (20 bits) carries the register address in bits 18:12 and 0 in bit 19 (bit 19 is the read flag: 1 = read, 0 = write). All other bits of the slot are 0.
- R2: For a write, the command data slot carries the 16-bit value in bits 19:4, and bits 3:0 are 0.
- R3: For a read, the command address slot carries 1 in bit 19 and `req_addr[6:0]` in bits 18:12, so bit 7 of the requested address is discarded. The command data slot is all zero.
- R4: Both tx tags are 1 from the first `frame_start` edge after a request is accepted until the next `frame_start` edge. At every other `frame_start` edge both tags and both slots are cleared to 0.
- R5: A write request whose address exceeds 0x7F (`req_addr[7]` = 1) is dropped: busy stays low, no tag is raised at the next frame, and no `wr_done` appears.
- R6: A read completes on a cycle with `rx_valid`, both rx tags set, and `rx_slot_addr[18:12]` equal to the requested address. On the next cycle `rd_done` pulses for one cycle and `rd_data` equals `rx_slot_data[19:4]`. `rd_data` changes only with `rd_done`.
- R7: On completion of a read, `addr_updated` is set only if the captured address differs from the previously held address, and `data_updated` only if the captured data differs from the previously held data. Both flags clear when the next request is accepted. The held values are 0 after reset.
- R8: While a read waits, a frame with a different status address, or without both rx tags, is ignored: busy stays high and `rd_data` is unchanged.
- R9: If TIMEOUT_FRAMES (default 4) `frame_start` edges pass after the read command went out without a matching status frame, `timeout` pulses for one cycle, busy falls and `rd_data` is unchanged.
- R10: `busy` is high from the cycle after a request is accepted. It falls in the same cycle that `wr_done`, `rd_done` or `timeout` pulses, and at most one of these pulses at a time.
- R11: After reset, `busy`, the done pulses, the tags, both slots, `rd_data` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address; bit 7 flags out-of-range |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Access in progress |
| wr_done | output | 1 | Write command sent (one-cycle pulse) |
| rd_done | output | 1 | Read value captured (one-cycle pulse) |
| rd_data | output | 16 | Last captured read value |
| timeout | output | 1 | Read abandoned (one-cycle pulse) |
| addr_updated | output | 1 | Captured status address changed |
| data_updated | output | 1 | Captured status data changed |
| frame_start | input | 1 | Outgoing frame boundary strobe |
| tx_tag_addr | output | 1 | Command address slot valid |
| tx_tag_data | output | 1 | Command data slot valid |
| tx_slot_addr | output | 20 | Command address slot |
| tx_slot_data | output | 20 | Command data slot |
| rx_valid | input | 1 | Incoming frame slots present |
| rx_tag_addr | input | 1 | Status address slot valid |
| rx_tag_data | input | 1 | Status data slot valid |
| rx_slot_addr | input | 20 | Status address slot |
| rx_slot_data | input | 20 | Status data slot |

## Verification
A sequencer stuck in its pending or waiting state shows as `busy` staying high and as a missing done pulse. The scoreboard reports this at the end of the affected access, within a few frames. A wrong latched command shows in the slot contents one cycle after the frame edge that loads them. A stale held address or held value inside the capture logic shows up only on the following read, as a wrong update flag. For that reason the bench reads the same register twice and then reads a different register that returns the same value.

// File: rtl/ac97_regacc_pkg.sv
// Package: slot geometry, access state and the command record shared by the
// register access controller. Assumes the standard 20-bit slot width.
package ac97_regacc_pkg;
    localparam int SLOT_W   = 20;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 16;
    localparam int RW_BIT   = SLOT_W - 1;
    localparam int ADDR_LSB = RW_BIT - ADDR_W;
    localparam int DATA_LSB = SLOT_W - DATA_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_WAIT = 2'd2
    } acc_state_e;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } acc_cmd_t;

    // Builds the command address slot: read flag on top, address below it.
    function automatic logic [SLOT_W-1:0] pack_addr_slot(input acc_cmd_t c);
        logic [SLOT_W-1:0] s;
        s = '0;
        s[RW_BIT] = c.is_read;
        s[RW_BIT-1:ADDR_LSB] = c.addr;
        return s;
    endfunction

    // Builds the command data slot: value left-aligned, zero for reads.
    function automatic logic [SLOT_W-1:0] pack_data_slot(input acc_cmd_t c);
        logic [SLOT_W-1:0] s;
        s = '0;
        if (!c.is_read) s[SLOT_W-1:DATA_LSB] = c.data;
        return s;
    endfunction
endpackage

// File: rtl/ac97_access_seq.sv
// Module: access sequencer. Accepts one host request at a time, drops
// out-of-range writes, waits for the next frame edge to send the command,
// and for reads waits for a matching status frame or a frame-count timeout.
// Assumes frame_start is a one-cycle strobe and status_hit is qualified.
module ac97_access_seq
    import ac97_regacc_pkg::*;
#(
    parameter int TIMEOUT_FRAMES = 4,
    localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              frame_start,
    input  logic              status_hit,
    output logic              accept,
    output logic              send,
    output logic              waiting_rd,
    output acc_cmd_t          cmd,
    output logic              busy,
    output logic              wr_done,
    output logic              timeout
);
    acc_state_e       state;
    logic [CNT_W-1:0] frames_left_cnt;

    // Request acceptance: idle, and not a write past the 7-bit space.
    assign accept     = req_valid && (state == ST_IDLE) && !(req_write && req_addr[ADDR_W]);
    assign send       = (state == ST_PEND) && frame_start;
    assign waiting_rd = (state == ST_WAIT);
    assign busy       = (state != ST_IDLE);

    // Sequencer state, latched command, timeout counter and done pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_IDLE;
            cmd             <= '0;
            frames_left_cnt <= '0;
            wr_done         <= 1'b0;
            timeout         <= 1'b0;
        end else begin
            wr_done <= 1'b0;
            timeout <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cmd.is_read <= !req_write;
                        cmd.addr    <= req_addr[ADDR_W-1:0];
                        cmd.data    <= req_write ? req_wdata : '0;
                        state       <= ST_PEND;
                    end
                end
                ST_PEND: begin
                    if (frame_start) begin
                        if (cmd.is_read) begin
                            frames_left_cnt <= '0;
                            state           <= ST_WAIT;
                        end else begin
                            wr_done <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                end
                ST_WAIT: begin
                    if (status_hit) begin
                        state <= ST_IDLE;
                    end else if (frame_start) begin
                        if (frames_left_cnt == CNT_W'(TIMEOUT_FRAMES - 1)) begin
                            timeout <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            frames_left_cnt <= frames_left_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: completion pulses are exclusive and coincide with busy low.
    p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_done, timeout, status_hit && waiting_rd}));
    p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done || timeout) |-> !busy);
    // R5: a dropped write never makes the sequencer busy.
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_write && req_addr[ADDR_W]) |=> !busy);
    // R9: a timeout only follows a frame edge.
    p_to_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(frame_start));
endmodule

// File: rtl/ac97_cmd_slot_tx.sv
// Module: command slot register. At each frame edge loads the command slots
// and raises both tags when a command is due, else clears tags and slots.
// Assumes send is only high together with frame_start.
module ac97_cmd_slot_tx
    import ac97_regacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              send,
    input  acc_cmd_t          cmd,
    output logic              tx_tag_addr,
    output logic              tx_tag_data,
    output logic [SLOT_W-1:0] tx_slot_addr,
    output logic [SLOT_W-1:0] tx_slot_data
);
    // Frame-aligned slot and tag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_tag_addr  <= 1'b0;
            tx_tag_data  <= 1'b0;
            tx_slot_addr <= '0;
            tx_slot_data <= '0;
        end else if (frame_start) begin
            tx_tag_addr  <= send;
            tx_tag_data  <= send;
            tx_slot_addr <= send ? pack_addr_slot(cmd) : '0;
            tx_slot_data <= send ? pack_data_slot(cmd) : '0;
        end
    end

    // R4: tags only change on a frame edge.
    p_tag_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tag_addr != $past(tx_tag_addr)) |-> $past(frame_start));
    // R1/R3: a tagged slot never has stray low bits.
    p_addr_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tag_addr |-> (tx_slot_addr[ADDR_LSB-1:0] == '0));
endmodule

// File: rtl/ac97_status_rx.sv
// Module: status capture. While a read waits, takes the first incoming frame
// with both status tags and the wanted address, stores the value and sets
// the update flags only where the new capture differs from the held one.
// Assumes clear_flags marks acceptance of a new request.
module ac97_status_rx
    import ac97_regacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              clear_flags,
    input  logic [ADDR_W-1:0] want_addr,
    input  logic              rx_valid,
    input  logic              rx_tag_addr,
    input  logic              rx_tag_data,
    input  logic [SLOT_W-1:0] rx_slot_addr,
    input  logic [SLOT_W-1:0] rx_slot_data,
    output logic              hit,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              addr_updated,
    output logic              data_updated
);
    logic [ADDR_W-1:0] new_addr;
    logic [DATA_W-1:0] new_data;
    logic [ADDR_W-1:0] held_addr;
    logic              unused_bits;

    assign new_addr    = rx_slot_addr[RW_BIT-1:ADDR_LSB];
    assign new_data    = rx_slot_data[SLOT_W-1:DATA_LSB];
    assign unused_bits = ^{rx_slot_addr[RW_BIT], rx_slot_addr[ADDR_LSB-1:0],
                           rx_slot_data[DATA_LSB-1:0]};
    assign hit = armed && rx_valid && rx_tag_addr && rx_tag_data && (new_addr == want_addr);

    // Capture of status address and data, with change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr    <= '0;
            rd_data      <= '0;
            rd_done      <= 1'b0;
            addr_updated <= 1'b0;
            data_updated <= 1'b0;
        end else begin
            rd_done <= hit;
            if (hit) begin
                held_addr    <= new_addr;
                rd_data      <= new_data;
                addr_updated <= (new_addr != held_addr);
                data_updated <= (new_data != rd_data);
            end else if (clear_flags) begin
                addr_updated <= 1'b0;
                data_updated <= 1'b0;
            end
        end
    end

    // R6: read value only moves together with the completion pulse.
    p_rd_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != $past(rd_data)) |-> rd_done);
    // R7: a flag can only rise at a completion.
    p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_updated) || $rose(data_updated)) |-> rd_done);
    // R7: an unchanged value never raises the data flag.
    p_same_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && (rd_data == $past(rd_data))) |-> !data_updated);
endmodule

// File: rtl/ac97_regacc_ctrl.sv
// Module: AC97 register access controller top. Connects the sequencer, the
// command slot register and the status capture. Assumes one access at a
// time and frame strobes from an external frame generator.
module ac97_regacc_ctrl
    import ac97_regacc_pkg::*;
#(
    parameter int TIMEOUT_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [15:0]       req_wdata,
    output logic              busy,
    output logic              wr_done,
    output logic              rd_done,
    output logic [15:0]       rd_data,
    output logic              timeout,
    output logic              addr_updated,
    output logic              data_updated,
    input  logic              frame_start,
    output logic              tx_tag_addr,
    output logic              tx_tag_data,
    output logic [19:0]       tx_slot_addr,
    output logic [19:0]       tx_slot_data,
    input  logic              rx_valid,
    input  logic              rx_tag_addr,
    input  logic              rx_tag_data,
    input  logic [19:0]       rx_slot_addr,
    input  logic [19:0]       rx_slot_data
);
    logic     accept;
    logic     send;
    logic     waiting_rd;
    logic     hit;
    acc_cmd_t cmd;

    ac97_access_seq #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .frame_start(frame_start), .status_hit(hit),
        .accept(accept), .send(send), .waiting_rd(waiting_rd), .cmd(cmd),
        .busy(busy), .wr_done(wr_done), .timeout(timeout)
    );

    ac97_cmd_slot_tx tx_i (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .send(send), .cmd(cmd),
        .tx_tag_addr(tx_tag_addr), .tx_tag_data(tx_tag_data),
        .tx_slot_addr(tx_slot_addr), .tx_slot_data(tx_slot_data)
    );

    ac97_status_rx rx_i (
        .clk(clk), .rst_n(rst_n),
        .armed(waiting_rd), .clear_flags(accept), .want_addr(cmd.addr),
        .rx_valid(rx_valid), .rx_tag_addr(rx_tag_addr), .rx_tag_data(rx_tag_data),
        .rx_slot_addr(rx_slot_addr), .rx_slot_data(rx_slot_data),
        .hit(hit), .rd_done(rd_done), .rd_data(rd_data),
        .addr_updated(addr_updated), .data_updated(data_updated)
    );

    // R10: read completion also leaves the controller idle.
    p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !busy);
    // R4: tags raised only while an access was in flight.
    p_tag_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_tag_addr) |-> $past(busy));
endmodule

// File: tb/ac97_regacc_ctrl_tb_top.sv
// Scoreboard bench: driver tasks queue the expected completion events, and a
// monitor compares them against the pulses the design produces.
module ac97_regacc_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, wr_done, rd_done, timeout, addr_updated, data_updated;
    logic [15:0] rd_data;
    logic        frame_start = 1'b0;
    logic        tx_tag_addr, tx_tag_data;
    logic [19:0] tx_slot_addr, tx_slot_data;
    logic        rx_valid = 1'b0, rx_tag_addr = 1'b0, rx_tag_data = 1'b0;
    logic [19:0] rx_slot_addr = '0, rx_slot_data = '0;

    int tests = 0;
    int fails = 0;
    logic [17:0] expq[$];   // {kind[1:0], value[15:0]}: 1 wr, 2 rd, 3 timeout
    logic [15:0] last_rd = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    ac97_regacc_ctrl dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every completion pulse must match the next queued item.
    always @(negedge clk) begin
        if (rst_n && (wr_done || rd_done || timeout)) begin
            logic [1:0] k;
            k = wr_done ? 2'd1 : (rd_done ? 2'd2 : 2'd3);
            if (expq.size() == 0) begin
                chk("R10 unexpected completion", {30'd0, k}, 32'd0);
            end else begin
                logic [17:0] e;
                e = expq.pop_front();
                chk("R10 completion kind", {30'd0, k}, {30'd0, e[17:16]});
                chk("R6/R9 rd_data at completion", {16'd0, rd_data}, {16'd0, e[15:0]});
                chk("R10 busy low at completion", {31'd0, busy}, 32'd0);
            end
        end
    end

    task automatic frame_pulse();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic request(input logic wr, input logic [7:0] a, input logic [15:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic status_frame(input logic ta, input logic td, input logic [6:0] a, input logic [15:0] d);
        rx_valid = 1'b1; rx_tag_addr = ta; rx_tag_data = td;
        rx_slot_addr = {1'b0, a, 12'h000}; rx_slot_data = {d, 4'h0};
        @(negedge clk);
        rx_valid = 1'b0; rx_tag_addr = 1'b0; rx_tag_data = 1'b0;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        request(1'b1, {1'b0, a}, d);
        chk("R10 busy after write accept", {31'd0, busy}, 32'd1);
        expq.push_back({2'd1, last_rd});
        frame_pulse();
        chk("R1 write addr slot", {12'd0, tx_slot_addr}, {12'd0, 1'b0, a, 12'h000});
        chk("R2 write data slot", {12'd0, tx_slot_data}, {12'd0, d, 4'h0});
        chk("R4 tags set", {30'd0, tx_tag_addr, tx_tag_data}, 32'd3);
    endtask

    // Read sends, optionally injects ignored frames, then the matching reply.
    task automatic do_read(input logic [7:0] a, input logic [15:0] d, input logic noise,
                           input logic exp_au, input logic exp_du);
        request(1'b0, a, 16'hFFFF);
        chk("R7 flags cleared on accept", {30'd0, addr_updated, data_updated}, 32'd0);
        frame_pulse();
        chk("R3 read addr slot", {12'd0, tx_slot_addr}, {12'd0, 1'b1, a[6:0], 12'h000});
        chk("R3 read data slot", {12'd0, tx_slot_data}, 32'd0);
        chk("R4 tags set on read", {30'd0, tx_tag_addr, tx_tag_data}, 32'd3);
        if (noise) begin
            status_frame(1'b1, 1'b1, a[6:0] ^ 7'h5A, 16'h1234);
            status_frame(1'b1, 1'b0, a[6:0], 16'h4321);
            chk("R8 busy after ignored frames", {31'd0, busy}, 32'd1);
            chk("R8 rd_data unchanged", {16'd0, rd_data}, {16'd0, last_rd});
        end
        last_rd = d;
        expq.push_back({2'd2, d});
        status_frame(1'b1, 1'b1, a[6:0], d);
        chk("R6 rd_done pulse", {31'd0, rd_done}, 32'd1);
        chk("R7 addr_updated", {31'd0, addr_updated}, {31'd0, exp_au});
        chk("R7 data_updated", {31'd0, data_updated}, {31'd0, exp_du});
        @(negedge clk);
        chk("R6 rd_done one cycle", {31'd0, rd_done}, 32'd0);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset busy", {31'd0, busy}, 32'd0);
        chk("R11 reset tags/slots", {tx_tag_addr, tx_tag_data, 10'd0, tx_slot_addr | tx_slot_data}, 32'd0);
        chk("R11 reset rd_data/flags", {14'd0, addr_updated, data_updated, rd_data}, 32'd0);

        do_write(7'h02, 16'h8000);
        do_write(7'h7F, 16'h00A5);
        frame_pulse();
        chk("R4 tags clear in next frame", {30'd0, tx_tag_addr, tx_tag_data}, 32'd0);
        chk("R4 slots clear in next frame", {12'd0, tx_slot_addr}, 32'd0);

        // R5: out-of-range write is dropped.
        request(1'b1, 8'h85, 16'hBEEF);
        chk("R5 busy stays low", {31'd0, busy}, 32'd0);
        frame_pulse();
        chk("R5 no tags", {30'd0, tx_tag_addr, tx_tag_data}, 32'd0);
        repeat (3) @(negedge clk);

        do_read(8'h7C, 16'h5958, 1'b0, 1'b1, 1'b1);   // R7 both changed
        do_read(8'h7C, 16'h5958, 1'b0, 1'b0, 1'b0);   // R7 same register twice
        do_read(8'hFC, 16'h5958, 1'b0, 1'b0, 1'b0);   // R3 masked address
        do_read(8'h26, 16'h5958, 1'b1, 1'b1, 1'b0);   // R8 noise, R7 address only
        do_read(8'h26, 16'h0F0F, 1'b0, 1'b0, 1'b1);   // R7 data only

        // R9: read with no reply times out after 4 frames.
        request(1'b0, 8'h10, 16'h0);
        frame_pulse();
        for (int i = 0; i < 3; i++) begin
            frame_pulse();
            chk("R9 busy before timeout", {31'd0, busy}, 32'd1);
        end
        expq.push_back({2'd3, last_rd});
        frame_pulse();
        chk("R9 timeout pulse", {31'd0, timeout}, 32'd1);
        @(negedge clk);
        chk("R9 flags stay clear", {30'd0, addr_updated, data_updated}, 32'd0);

        repeat (4) @(negedge clk);
        chk("R10 scoreboard drained", expq.size(), 32'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule